// File: doc/BRIEF.md
# Pass Transistor Energy Limiter

This block keeps a running estimate of the heat deposited in an external pass transistor that carries a pulsed load current. While the pulse is on, each ADC sample tick adds the present voltage code to an accumulator. When the ADC sits at full scale, the code added is multiplied by a selectable factor, because the true voltage is then above what the converter can show. While the pulse is off, a slower decay tick takes a programmed step off the accumulator. This models the transistor cooling down.

When an accumulation brings the estimate up to a programmed threshold, the block clears the accumulator. It then raises an inhibit output for a programmed number of seconds, counted on a one-per-second tick input. The pulse generator must stay off for that whole time. The accumulated value is always visible on an output for software or a monitor to read.

Top module: `pulse_energy_limiter`

## Requirements
- R1: After reset, energy_o is 0 and cooldown_o is 0.
- R2: A clock edge with pulse_on_i=1, sample_tick_i=1 and cooldown_o=0 adds adc_code_i to energy_o, visible after that edge, when the code is below full scale (not all ones).
- R3: When adc_code_i is all ones (0xFF), the amount added is the code times a factor chosen by ovr_scale_i: 0 gives x1, 1 gives x4, 2 gives x8, 3 gives x16.
- R4: The sum clamps at all ones (0xFFFF) and never wraps. A clamped sum always meets any threshold, so it enters cooldown.
- R5: If the sum after an accumulation is greater than or equal to thr_i, then after that edge cooldown_o is 1 and energy_o is 0.
- R6: An edge with pulse_on_i=0 and decay_tick_i=1 subtracts decay_step_i from energy_o, stopping at 0. A decay tick while pulse_on_i=1 has no effect.
- R7: While cooldown_o is 1, sample ticks are ignored and energy_o stays 0.
- R8: On entry to cooldown, a second count is loaded from cool_sec_i. A sec_tick_i in the entry cycle is not counted. cooldown_o falls after the tick that uses up the count, and a count of 0 or 1 both last one tick.
- R9: On an edge with no tick input high, energy_o and cooldown_o hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pulse_on_i | input | 1 | High-current pulse is active |
| sample_tick_i | input | 1 | ADC sample strobe, one cycle |
| decay_tick_i | input | 1 | Cooling step strobe, one cycle |
| sec_tick_i | input | 1 | One-second strobe, one cycle |
| adc_code_i | input | 8 | Sampled voltage code |
| thr_i | input | 16 | Energy limit |
| decay_step_i | input | 4 | Amount removed per decay tick |
| cool_sec_i | input | 4 | Cooldown length in seconds |
| ovr_scale_i | input | 2 | Full-scale multiplier select |
| energy_o | output | 16 | Accumulated energy estimate |
| cooldown_o | output | 1 | Pulse inhibit, high during cooldown |

## Verification
Two collisions can happen in a single cycle, and the bench provokes both.

The first is a sample tick and a decay tick together. With the pulse on, only the add may take effect. With the pulse off, only the step down may take effect.

The second is a threshold crossing that lands on a one-second tick. The freshly loaded cooldown count must not lose a second to it. The bench judges this by counting the later second ticks until cooldown_o falls.

// File: rtl/pel_pkg.sv
package pel_pkg;
  typedef enum logic [1:0] {OVR_X1 = 2'd0, OVR_X4 = 2'd1, OVR_X8 = 2'd2, OVR_X16 = 2'd3} ovr_e;

  function automatic int unsigned ovr_shift(input logic [1:0] sel);
    case (ovr_e'(sel))
      OVR_X1:  return 0;
      OVR_X4:  return 2;
      OVR_X8:  return 3;
      default: return 4;
    endcase
  endfunction
endpackage

// File: rtl/pel_scaler.sv
module pel_scaler #(
  parameter int ADC_W = 8,
  parameter int ADD_W = ADC_W + 4
) (
  input  logic [ADC_W-1:0] code_i,
  input  logic [1:0]       sel_i,
  output logic [ADD_W-1:0] addend_o
);
  logic             full;
  logic [ADD_W-1:0] wide;

  assign full = &code_i;
  assign wide = {{(ADD_W-ADC_W){1'b0}}, code_i};

  always_comb begin
    if (full) addend_o = wide << pel_pkg::ovr_shift(sel_i);
    else      addend_o = wide;
  end
endmodule

// File: rtl/pel_accum.sv
module pel_accum #(
  parameter int ACC_W  = 16,
  parameter int ADD_W  = 12,
  parameter int STEP_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              add_en_i,
  input  logic [ADD_W-1:0]  addend_i,
  input  logic              decay_en_i,
  input  logic [STEP_W-1:0] step_i,
  input  logic [ACC_W-1:0]  thr_i,
  output logic              trip_o,
  output logic [ACC_W-1:0]  acc_o
);
  logic [ACC_W-1:0] acc_q;
  logic [ACC_W:0]   sum;
  logic [ACC_W-1:0] sum_sat;
  logic [ACC_W-1:0] step_ext;
  logic [ACC_W-1:0] decayed;

  assign sum      = {1'b0, acc_q} + {{(ACC_W+1-ADD_W){1'b0}}, addend_i};
  assign sum_sat  = sum[ACC_W] ? '1 : sum[ACC_W-1:0];
  assign step_ext = {{(ACC_W-STEP_W){1'b0}}, step_i};
  assign decayed  = (acc_q >= step_ext) ? acc_q - step_ext : '0;
  assign trip_o   = add_en_i && (sum_sat >= thr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         acc_q <= '0;
    else if (add_en_i)   acc_q <= trip_o ? '0 : sum_sat;
    else if (decay_en_i) acc_q <= decayed;
  end

  assign acc_o = acc_q;
endmodule

// File: rtl/pel_cooldown.sv
module pel_cooldown #(
  parameter int SEC_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             sec_tick_i,
  input  logic [SEC_W-1:0] sec_i,
  output logic             active_o
);
  logic             active_q;
  logic [SEC_W-1:0] remain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      remain_q <= '0;
    end else if (start_i) begin
      active_q <= 1'b1;
      remain_q <= sec_i;
    end else if (active_q && sec_tick_i) begin
      if (remain_q <= SEC_W'(1)) begin
        active_q <= 1'b0;
        remain_q <= '0;
      end else begin
        remain_q <= remain_q - SEC_W'(1);
      end
    end
  end

  assign active_o = active_q;
endmodule

// File: rtl/pulse_energy_limiter.sv
module pulse_energy_limiter #(
  parameter int ADC_W  = 8,
  parameter int ACC_W  = 16,
  parameter int STEP_W = 4,
  parameter int SEC_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pulse_on_i,
  input  logic              sample_tick_i,
  input  logic              decay_tick_i,
  input  logic              sec_tick_i,
  input  logic [ADC_W-1:0]  adc_code_i,
  input  logic [ACC_W-1:0]  thr_i,
  input  logic [STEP_W-1:0] decay_step_i,
  input  logic [SEC_W-1:0]  cool_sec_i,
  input  logic [1:0]        ovr_scale_i,
  output logic [ACC_W-1:0]  energy_o,
  output logic              cooldown_o
);
  localparam int ADD_W = ADC_W + 4;

  logic [ADD_W-1:0] addend;
  logic             add_en;
  logic             decay_en;
  logic             trip;
  logic             cool_active;

  assign add_en   = pulse_on_i && sample_tick_i && !cool_active;
  assign decay_en = !pulse_on_i && decay_tick_i;

  pel_scaler #(.ADC_W(ADC_W), .ADD_W(ADD_W)) u_scaler (
    .code_i   (adc_code_i),
    .sel_i    (ovr_scale_i),
    .addend_o (addend)
  );

  pel_accum #(.ACC_W(ACC_W), .ADD_W(ADD_W), .STEP_W(STEP_W)) u_accum (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .add_en_i   (add_en),
    .addend_i   (addend),
    .decay_en_i (decay_en),
    .step_i     (decay_step_i),
    .thr_i      (thr_i),
    .trip_o     (trip),
    .acc_o      (energy_o)
  );

  pel_cooldown #(.SEC_W(SEC_W)) u_cool (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (trip),
    .sec_tick_i (sec_tick_i),
    .sec_i      (cool_sec_i),
    .active_o   (cool_active)
  );

  assign cooldown_o = cool_active;
endmodule

// File: rtl/pel_checker.sv
module pel_checker #(
  parameter int ACC_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             pulse_on_i,
  input logic             sample_tick_i,
  input logic             decay_tick_i,
  input logic             sec_tick_i,
  input logic [ACC_W-1:0] energy_o,
  input logic             cooldown_o
);
  a_r5_clear_on_entry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cooldown_o) |-> energy_o == '0);

  a_r7_zero_in_cooldown: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cooldown_o |-> energy_o == '0);

  a_r2_entry_needs_sample: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cooldown_o) |-> $past(pulse_on_i && sample_tick_i));

  a_r4_no_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pulse_on_i && sample_tick_i && !cooldown_o) |=> (cooldown_o || energy_o >= $past(energy_o)));

  a_r6_idle_no_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pulse_on_i && !cooldown_o) |=> energy_o <= $past(energy_o));

  a_r8_exit_on_second: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cooldown_o) |-> $past(sec_tick_i));

  a_r9_hold_no_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sample_tick_i && !decay_tick_i && !sec_tick_i) |=> ($stable(energy_o) && $stable(cooldown_o)));
endmodule

bind pulse_energy_limiter pel_checker #(.ACC_W(ACC_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .pulse_on_i    (pulse_on_i),
  .sample_tick_i (sample_tick_i),
  .decay_tick_i  (decay_tick_i),
  .sec_tick_i    (sec_tick_i),
  .energy_o      (energy_o),
  .cooldown_o    (cooldown_o)
);

// File: tb/pulse_energy_limiter_tb.sv
module pulse_energy_limiter_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pulse = 1'b0, smp = 1'b0, dec = 1'b0, sec = 1'b0;
  logic [7:0]  adc = '0;
  logic [15:0] thr = 16'd459;
  logic [3:0]  step = 4'd5;
  logic [3:0]  cool = 4'd2;
  logic [1:0]  ovr = 2'd2;
  logic [15:0] energy;
  logic        cd;
  int          n_chk = 0, n_fail = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  pulse_energy_limiter u_dut (
    .clk_i(clk), .rst_ni(rst_n), .pulse_on_i(pulse), .sample_tick_i(smp),
    .decay_tick_i(dec), .sec_tick_i(sec), .adc_code_i(adc), .thr_i(thr),
    .decay_step_i(step), .cool_sec_i(cool), .ovr_scale_i(ovr),
    .energy_o(energy), .cooldown_o(cd)
  );

  typedef struct packed {
    logic p; logic s; logic d; logic t;
    logic [7:0] code; logic [15:0] exp_e; logic exp_c; logic [7:0] tag;
  } vec_t;

  // config: thr 459, step 5, cool 2 s, full-scale x8
  localparam vec_t VEC [13] = '{
    '{1'b1,1'b1,1'b0,1'b0,8'h40,16'd64,  1'b0,8'd2},
    '{1'b1,1'b1,1'b0,1'b0,8'h80,16'd192, 1'b0,8'd2},
    '{1'b1,1'b0,1'b0,1'b0,8'h80,16'd192, 1'b0,8'd9},
    '{1'b0,1'b0,1'b1,1'b0,8'h00,16'd187, 1'b0,8'd6},
    '{1'b0,1'b1,1'b1,1'b0,8'h00,16'd182, 1'b0,8'd6},
    '{1'b1,1'b1,1'b1,1'b0,8'h0A,16'd192, 1'b0,8'd6},
    '{1'b0,1'b0,1'b0,1'b0,8'h00,16'd192, 1'b0,8'd9},
    '{1'b1,1'b1,1'b0,1'b1,8'hFF,16'd0,   1'b1,8'd5},
    '{1'b1,1'b1,1'b0,1'b0,8'h50,16'd0,   1'b1,8'd7},
    '{1'b0,1'b0,1'b0,1'b1,8'h00,16'd0,   1'b1,8'd8},
    '{1'b0,1'b0,1'b0,1'b1,8'h00,16'd0,   1'b0,8'd8},
    '{1'b1,1'b1,1'b0,1'b0,8'h64,16'd100, 1'b0,8'd2},
    '{1'b0,1'b0,1'b1,1'b0,8'h00,16'd95,  1'b0,8'd6}
  };

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic apply(input logic p, input logic s, input logic d, input logic t, input logic [7:0] c);
    pulse = p; smp = s; dec = d; sec = t; adc = c;
    @(negedge clk);
    smp = 1'b0; dec = 1'b0; sec = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    pulse = 1'b0; smp = 1'b0; dec = 1'b0; sec = 1'b0; adc = '0;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL R9: watchdog expired, actual 0 expected 1 (run finished)");
      finish_run();
    end
  end

  initial begin
    @(negedge clk); @(negedge clk);
    chk("R1 energy", energy, 0);
    chk("R1 cooldown", cd, 0);
    rst_n = 1'b1;
    @(negedge clk);

    foreach (VEC[i]) begin
      apply(VEC[i].p, VEC[i].s, VEC[i].d, VEC[i].t, VEC[i].code);
      chk($sformatf("R%0d vec%0d energy", VEC[i].tag, i), energy, VEC[i].exp_e);
      chk($sformatf("R%0d vec%0d cooldown", VEC[i].tag, i), cd, VEC[i].exp_c);
    end

    // R3 full-scale factors, R2 near-full code unscaled
    thr = 16'hFFFF; cool = 4'd1; do_reset();
    begin
      int acc_exp = 0;
      for (int k = 0; k < 4; k++) begin
        ovr = 2'(k);
        apply(1'b1, 1'b1, 1'b0, 1'b0, 8'hFF);
        acc_exp += 255 << ((k == 0) ? 0 : k + 1);
        chk($sformatf("R3 factor sel %0d", k), energy, acc_exp);
      end
      ovr = 2'd3;
      apply(1'b1, 1'b1, 1'b0, 1'b0, 8'hFE);
      chk("R2 code 0xFE unscaled", energy, acc_exp + 254);
    end

    // R4 clamp instead of wrap
    do_reset(); ovr = 2'd3;
    for (int k = 0; k < 16; k++) apply(1'b1, 1'b1, 1'b0, 1'b0, 8'hFF);
    chk("R4 pre-clamp energy", energy, 65280);
    chk("R4 pre-clamp cooldown", cd, 0);
    apply(1'b1, 1'b1, 1'b0, 1'b0, 8'hFF);
    chk("R4 clamp trips cooldown", cd, 1);
    chk("R4 clamp energy cleared", energy, 0);

    // R6 decay floor and decay ignored while pulse on
    do_reset(); ovr = 2'd0; step = 4'd5;
    apply(1'b1, 1'b1, 1'b0, 1'b0, 8'd3);
    apply(1'b1, 1'b0, 1'b1, 1'b0, 8'd3);
    chk("R6 decay ignored with pulse on", energy, 3);
    apply(1'b0, 1'b0, 1'b1, 1'b0, 8'd0);
    chk("R6 decay floors at 0", energy, 0);
    apply(1'b0, 1'b0, 1'b1, 1'b0, 8'd0);
    chk("R6 decay stays 0", energy, 0);

    // R5 equality trips
    thr = 16'd100; do_reset();
    apply(1'b1, 1'b1, 1'b0, 1'b0, 8'd99);
    chk("R5 below threshold", cd, 0);
    apply(1'b1, 1'b1, 1'b0, 1'b0, 8'd1);
    chk("R5 equal trips", cd, 1);
    chk("R5 energy cleared", energy, 0);

    // R8 three-second cooldown, R9 hold
    thr = 16'd1; cool = 4'd3; do_reset();
    apply(1'b1, 1'b1, 1'b0, 1'b0, 8'd5);
    chk("R8 entry", cd, 1);
    apply(1'b0, 1'b0, 1'b0, 1'b0, 8'd0);
    chk("R9 hold without tick", cd, 1);
    apply(1'b0, 1'b0, 1'b0, 1'b1, 8'd0);
    chk("R8 after 1 s", cd, 1);
    apply(1'b0, 1'b0, 1'b0, 1'b1, 8'd0);
    chk("R8 after 2 s", cd, 1);
    apply(1'b0, 1'b0, 1'b0, 1'b1, 8'd0);
    chk("R8 after 3 s", cd, 0);

    // R8 zero count lasts one tick
    cool = 4'd0; do_reset();
    apply(1'b1, 1'b1, 1'b0, 1'b0, 8'd5);
    chk("R8 zero-count entry", cd, 1);
    apply(1'b0, 1'b0, 1'b0, 1'b1, 8'd0);
    chk("R8 zero-count exit", cd, 0);

    done = 1'b1;
    finish_run();
  end
endmodule